// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block decides where the instruction stream goes after each instruction. Every cycle it takes the current program counter, a decoded control-transfer class, the instruction's immediate fields, the two source operand values, and the contents of the three return-address registers. One clock later it presents the next program counter. Where the instruction saves a return address it also presents a register write, and for exception return it presents a request to restore the status word.

The block fits between decode and fetch. Decode supplies the class code, the condition code and the register indices. The register file supplies the operand values. Fetch consumes `next_pc`. The register-file writer consumes the link write, and the control-register logic consumes `status_restore`. Branch conditions are evaluated inside the block, so no separate comparator is needed in the datapath. A source index of 0 always reads as zero here, whatever value the register file drives.

Top module: `bnpc_top`

## Requirements
- R1: While `rst` is high, at the next clock edge `next_pc` becomes the parameter RESET_PC (default 0), and `link_we` and `status_restore` become 0.
- R2: Class 1 (absolute jump): `next_pc` keeps the top four bits of `cur_pc` and fills the rest with `imm26` shifted left by two. There is no link write.
- R3: Class 2 (absolute call): `next_pc` is the same target as R2. In addition, `link_we`=1, `link_idx`=31 and `link_val`=`cur_pc`+4.
- R4: Class 3 (unconditional relative branch): `next_pc` = `cur_pc` + 4 + (sign-extended `imm16` with bits 1:0 forced to zero).
- R5: Class 4 (conditional branch) compares operand A with operand B. The `br_cond` codes are 0 equal, 1 not equal, 2 signed greater-or-equal, 3 signed less-than, 4 unsigned greater-or-equal, 5 unsigned less-than, and 6 and 7 never taken. When taken, `next_pc` is the R4 target; otherwise it is `cur_pc`+4.
- R6: Class 5 loads `next_pc` from `ea_val` and raises `status_restore`. Class 6 loads it from `ba_val`, and class 7 loads it from `ra_val`. `status_restore` is high only for class 5.
- R7: Class 8 (indirect jump) loads `next_pc` from operand A. Class 9 (indirect call) does the same and also writes `cur_pc`+4 to register 31.
- R8: Class 10 sets `next_pc` to `cur_pc`+4 and writes `cur_pc`+4 to register `regc_idx`. The write is suppressed (`link_we`=0) when `regc_idx` is 0.
- R9: Class 0 and the unused classes 11 to 15 give `next_pc` = `cur_pc`+4, with `link_we`=0 and `status_restore`=0.
- R10: An operand whose index (`rega_idx` or `regb_idx`) is 0 is taken as zero. The value on `rega_val` or `regb_val` is then ignored, both in comparisons and in indirect targets.
- R11: All outputs are registered. They change only at the clock edge that follows the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 32 | PC of the current instruction |
| ctl_class | input | 4 | Control-transfer class code |
| br_cond | input | 3 | Branch condition code |
| imm16 | input | 16 | Relative branch immediate |
| imm26 | input | 26 | Absolute jump immediate |
| rega_idx | input | 5 | Index of operand A |
| regb_idx | input | 5 | Index of operand B |
| regc_idx | input | 5 | Destination index for class 10 |
| rega_val | input | 32 | Register value for operand A |
| regb_val | input | 32 | Register value for operand B |
| ea_val | input | 32 | Exception return address |
| ba_val | input | 32 | Breakpoint return address |
| ra_val | input | 32 | Return address register |
| next_pc | output | 32 | Registered next program counter |
| link_we | output | 1 | Registered link write enable |
| link_idx | output | 5 | Registered link destination index |
| link_val | output | 32 | Registered link value |
| status_restore | output | 1 | Registered request to copy saved status into status |

## Verification
Conditional branches are run with all eight condition codes against operand pairs that are equal, that differ only in sign interpretation (all-ones against one, and the reverse), and that are plainly ordered. These pairs separate signed from unsigned comparison and equality from ordering. Relative branches use positive offsets, negative offsets and offsets with the low bits set, which exposes any failure to sign-extend or to clear those bits. Absolute jumps use PCs with a non-zero top nibble, so a dropped region field shows up. Zero-index operands are driven with non-zero register values, so the outputs show any leak of the ignored value.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;
  typedef enum logic [3:0] {
    CT_NONE     = 4'd0,
    CT_JABS     = 4'd1,
    CT_CABS     = 4'd2,
    CT_BRREL    = 4'd3,
    CT_BRCOND   = 4'd4,
    CT_XRET     = 4'd5,
    CT_DRET     = 4'd6,
    CT_RET      = 4'd7,
    CT_JIND     = 4'd8,
    CT_CIND     = 4'd9,
    CT_NEXTPC   = 4'd10
  } ctl_class_e;

  typedef enum logic [2:0] {
    CC_EQ  = 3'd0,
    CC_NE  = 3'd1,
    CC_GE  = 3'd2,
    CC_LT  = 3'd3,
    CC_GEU = 3'd4,
    CC_LTU = 3'd5
  } cond_e;
endpackage

// File: rtl/bnpc_opsel.sv
// Zero-register gating of one source operand.
module bnpc_opsel #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic [AW-1:0]   idx,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] val
);
  always_comb begin
    if (idx == '0) val = '0;
    else           val = raw;
  end
endmodule

// File: rtl/bnpc_cond.sv
// Branch condition evaluation.
module bnpc_cond #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            take
);
  import bnpc_pkg::*;
  logic eq, slt, ult;

  always_comb begin
    eq  = (a == b);
    slt = ($signed(a) < $signed(b));
    ult = (a < b);
    case (cond)
      CC_EQ:   take = eq;
      CC_NE:   take = !eq;
      CC_GE:   take = !slt;
      CC_LT:   take = slt;
      CC_GEU:  take = !ult;
      CC_LTU:  take = ult;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/bnpc_target.sv
// Next-PC selection across all control-transfer classes.
module bnpc_target #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int JIMM_W = 26
) (
  input  logic [3:0]        cls,
  input  logic [XLEN-1:0]   pc,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [JIMM_W-1:0] imm26,
  input  logic [XLEN-1:0]   a_val,
  input  logic [XLEN-1:0]   ea,
  input  logic [XLEN-1:0]   ba,
  input  logic [XLEN-1:0]   ra,
  input  logic              take,
  output logic [XLEN-1:0]   pc_inc,
  output logic [XLEN-1:0]   npc
);
  import bnpc_pkg::*;
  localparam int REGION_W = XLEN - JIMM_W - 2;

  logic [XLEN-1:0] sext, rel_tgt, abs_tgt;

  always_comb begin
    pc_inc  = pc + XLEN'(4);
    sext    = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
    rel_tgt = pc_inc + {sext[XLEN-1:2], 2'b00};
    abs_tgt = {pc[XLEN-1 -: REGION_W], imm26, 2'b00};
    case (cls)
      CT_JABS, CT_CABS: npc = abs_tgt;
      CT_BRREL:         npc = rel_tgt;
      CT_BRCOND:        npc = take ? rel_tgt : pc_inc;
      CT_XRET:          npc = ea;
      CT_DRET:          npc = ba;
      CT_RET:           npc = ra;
      CT_JIND, CT_CIND: npc = a_val;
      default:          npc = pc_inc;
    endcase
  end
endmodule

// File: rtl/bnpc_link.sv
// Link-register write decision.
module bnpc_link #(
  parameter int XLEN   = 32,
  parameter int AW     = 5,
  parameter int RA_IDX = 31
) (
  input  logic [3:0]      cls,
  input  logic [AW-1:0]   regc,
  input  logic [XLEN-1:0] pc_inc,
  output logic            we,
  output logic [AW-1:0]   idx,
  output logic [XLEN-1:0] val,
  output logic            srest
);
  import bnpc_pkg::*;
  always_comb begin
    we    = 1'b0;
    idx   = '0;
    srest = (cls == CT_XRET);
    case (cls)
      CT_CABS, CT_CIND: begin
        we  = 1'b1;
        idx = AW'(RA_IDX);
      end
      CT_NEXTPC: begin
        we  = (regc != '0);
        idx = regc;
      end
      default: ;
    endcase
    val = we ? pc_inc : '0;
  end
endmodule

// File: rtl/bnpc_top.sv
module bnpc_top #(
  parameter int          XLEN     = 32,
  parameter int          AW       = 5,
  parameter int          IMM_W    = 16,
  parameter int          JIMM_W   = 26,
  parameter int          RA_IDX   = 31,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [3:0]        ctl_class,
  input  logic [2:0]        br_cond,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [JIMM_W-1:0] imm26,
  input  logic [AW-1:0]     rega_idx,
  input  logic [AW-1:0]     regb_idx,
  input  logic [AW-1:0]     regc_idx,
  input  logic [XLEN-1:0]   rega_val,
  input  logic [XLEN-1:0]   regb_val,
  input  logic [XLEN-1:0]   ea_val,
  input  logic [XLEN-1:0]   ba_val,
  input  logic [XLEN-1:0]   ra_val,
  output logic [XLEN-1:0]   next_pc,
  output logic              link_we,
  output logic [AW-1:0]     link_idx,
  output logic [XLEN-1:0]   link_val,
  output logic              status_restore
);
  import bnpc_pkg::*;
  localparam int NOPS = 2;

  logic [AW-1:0]   op_idx [NOPS];
  logic [XLEN-1:0] op_raw [NOPS];
  logic [XLEN-1:0] op_val [NOPS];

  assign op_idx[0] = rega_idx;
  assign op_idx[1] = regb_idx;
  assign op_raw[0] = rega_val;
  assign op_raw[1] = regb_val;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    bnpc_opsel #(.XLEN(XLEN), .AW(AW)) u_sel (
      .idx(op_idx[g]), .raw(op_raw[g]), .val(op_val[g])
    );
  end

  logic            take;
  logic [XLEN-1:0] pc_inc, npc_d, lval_d;
  logic            lwe_d, srest_d;
  logic [AW-1:0]   lidx_d;

  bnpc_cond #(.XLEN(XLEN)) u_cond (
    .cond(br_cond), .a(op_val[0]), .b(op_val[1]), .take(take)
  );

  bnpc_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JIMM_W(JIMM_W)) u_tgt (
    .cls(ctl_class), .pc(cur_pc), .imm16(imm16), .imm26(imm26),
    .a_val(op_val[0]), .ea(ea_val), .ba(ba_val), .ra(ra_val),
    .take(take), .pc_inc(pc_inc), .npc(npc_d)
  );

  bnpc_link #(.XLEN(XLEN), .AW(AW), .RA_IDX(RA_IDX)) u_link (
    .cls(ctl_class), .regc(regc_idx), .pc_inc(pc_inc),
    .we(lwe_d), .idx(lidx_d), .val(lval_d), .srest(srest_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc        <= XLEN'(RESET_PC);
      link_we        <= 1'b0;
      link_idx       <= '0;
      link_val       <= '0;
      status_restore <= 1'b0;
    end else begin
      next_pc        <= npc_d;
      link_we        <= lwe_d;
      link_idx       <= lidx_d;
      link_val       <= lval_d;
      status_restore <= srest_d;
    end
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (next_pc == XLEN'(RESET_PC) && !link_we && !status_restore));

  // R3
  a_r3_call_links: assert property (@(posedge clk) disable iff (rst)
    (ctl_class == CT_CABS) |=>
      (link_we && link_idx == AW'(RA_IDX) && link_val == $past(cur_pc) + XLEN'(4)));

  // R6
  a_r6_xret_restore: assert property (@(posedge clk) disable iff (rst)
    (ctl_class == CT_XRET) |=> (status_restore && next_pc == $past(ea_val)));

  // R8
  a_r8_nextpc_r0: assert property (@(posedge clk) disable iff (rst)
    (ctl_class == CT_NEXTPC && regc_idx == '0) |=> !link_we);

  // R9
  a_r9_plain_step: assert property (@(posedge clk) disable iff (rst)
    (ctl_class == CT_NONE) |=>
      (next_pc == $past(cur_pc) + XLEN'(4) && !link_we && !status_restore));

  // R10
  a_r10_jind_zero: assert property (@(posedge clk) disable iff (rst)
    (ctl_class == CT_JIND && rega_idx == '0) |=> (next_pc == '0));
endmodule

// File: tb/bnpc_top_test.sv
module bnpc_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] cur_pc;
  logic [3:0]  ctl_class;
  logic [2:0]  br_cond;
  logic [15:0] imm16;
  logic [25:0] imm26;
  logic [4:0]  rega_idx, regb_idx, regc_idx;
  logic [31:0] rega_val, regb_val, ea_val, ba_val, ra_val;
  logic [31:0] next_pc;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_val;
  logic        status_restore;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bnpc_top uut (
    .clk(clk), .rst(rst), .cur_pc(cur_pc), .ctl_class(ctl_class),
    .br_cond(br_cond), .imm16(imm16), .imm26(imm26),
    .rega_idx(rega_idx), .regb_idx(regb_idx), .regc_idx(regc_idx),
    .rega_val(rega_val), .regb_val(regb_val), .ea_val(ea_val),
    .ba_val(ba_val), .ra_val(ra_val), .next_pc(next_pc),
    .link_we(link_we), .link_idx(link_idx), .link_val(link_val),
    .status_restore(status_restore)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rel_t(logic [31:0] pc, logic [15:0] im);
    logic [31:0] s;
    s = {{16{im[15]}}, im};
    s[1:0] = 2'b00;
    return pc + 32'd4 + s;
  endfunction

  function automatic bit cond_ref(int c, logic [31:0] a, logic [31:0] b);
    case (c)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) >= $signed(b);
      3: return $signed(a) < $signed(b);
      4: return a >= b;
      5: return a < b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic idle_inputs();
    ctl_class = 4'd0; br_cond = 3'd0; imm16 = '0; imm26 = '0;
    rega_idx = 5'd1; regb_idx = 5'd2; regc_idx = 5'd3;
    rega_val = 32'h11110000; regb_val = 32'h22220000;
    ea_val = 32'hEA00_0010; ba_val = 32'hBA00_0020; ra_val = 32'hAA00_0030;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle_inputs();
    cur_pc = 32'h1234_5678;
    ctl_class = 4'd2;
    step(); step();
    chk("R1 next_pc", next_pc, 32'h0);
    chk("R1 link_we", {31'd0, link_we}, 32'd0);
    chk("R1 status_restore", {31'd0, status_restore}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_jump_abs();
    idle_inputs();
    cur_pc = 32'hA000_1000; ctl_class = 4'd1; imm26 = 26'h2AB_CDEF;
    #1;
    chk("R11 output held before edge", next_pc, 32'h0);
    step();
    chk("R2 abs target", next_pc, {4'hA, 26'h2AB_CDEF, 2'b00});
    chk("R2 no link", {31'd0, link_we}, 32'd0);
  endtask

  task automatic t_call_abs();
    idle_inputs();
    cur_pc = 32'h7FFF_FFFC; ctl_class = 4'd2; imm26 = 26'h000_0040;
    step();
    chk("R3 call target", next_pc, 32'h7000_0100);
    chk("R3 link_we", {31'd0, link_we}, 32'd1);
    chk("R3 link_idx", {27'd0, link_idx}, 32'd31);
    chk("R3 link_val", link_val, 32'h8000_0000);
  endtask

  task automatic t_branch();
    logic [15:0] ims [3] = '{16'h0010, 16'hFFF3, 16'h7FFF};
    for (int i = 0; i < 3; i++) begin
      idle_inputs();
      cur_pc = 32'h0000_2000; ctl_class = 4'd3; imm16 = ims[i];
      step();
      chk("R4 relative target", next_pc, rel_t(32'h0000_2000, ims[i]));
    end
  endtask

  task automatic t_cond();
    logic [31:0] av [4] = '{32'd5, 32'hFFFF_FFFF, 32'd1, 32'd3};
    logic [31:0] bv [4] = '{32'd5, 32'd1, 32'hFFFF_FFFF, 32'd7};
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 8; c++) begin
        idle_inputs();
        cur_pc = 32'h0000_4000; ctl_class = 4'd4; br_cond = 3'(c);
        imm16 = 16'hFF00; rega_val = av[p]; regb_val = bv[p];
        step();
        chk("R5 conditional", next_pc,
            cond_ref(c, av[p], bv[p]) ? rel_t(32'h0000_4000, 16'hFF00)
                                      : 32'h0000_4004);
      end
    end
  endtask

  task automatic t_returns();
    idle_inputs(); cur_pc = 32'h100; ctl_class = 4'd5;
    step();
    chk("R6 xret pc", next_pc, 32'hEA00_0010);
    chk("R6 xret restore", {31'd0, status_restore}, 32'd1);
    ctl_class = 4'd6;
    step();
    chk("R6 dret pc", next_pc, 32'hBA00_0020);
    chk("R6 dret no restore", {31'd0, status_restore}, 32'd0);
    ctl_class = 4'd7;
    step();
    chk("R6 ret pc", next_pc, 32'hAA00_0030);
    chk("R6 ret no link", {31'd0, link_we}, 32'd0);
  endtask

  task automatic t_indirect();
    idle_inputs(); cur_pc = 32'h0000_0800; ctl_class = 4'd8;
    rega_val = 32'h0040_0000;
    step();
    chk("R7 jind target", next_pc, 32'h0040_0000);
    chk("R7 jind no link", {31'd0, link_we}, 32'd0);
    ctl_class = 4'd9; rega_val = 32'h0050_0004;
    step();
    chk("R7 cind target", next_pc, 32'h0050_0004);
    chk("R7 cind link_idx", {27'd0, link_idx}, 32'd31);
    chk("R7 cind link_val", link_val, 32'h0000_0804);
  endtask

  task automatic t_nextpc();
    idle_inputs(); cur_pc = 32'h0000_0900; ctl_class = 4'd10; regc_idx = 5'd7;
    step();
    chk("R8 next_pc", next_pc, 32'h0000_0904);
    chk("R8 link_we", {31'd0, link_we}, 32'd1);
    chk("R8 link_idx", {27'd0, link_idx}, 32'd7);
    chk("R8 link_val", link_val, 32'h0000_0904);
    regc_idx = 5'd0;
    step();
    chk("R8 r0 suppressed", {31'd0, link_we}, 32'd0);
  endtask

  task automatic t_nonctl();
    for (int c = 0; c < 16; c++) begin
      if (c != 0 && c < 11) continue;
      idle_inputs(); cur_pc = 32'h0000_0A00 + 32'(c * 16); ctl_class = 4'(c);
      step();
      chk("R9 sequential", next_pc, 32'h0000_0A04 + 32'(c * 16));
      chk("R9 no link", {31'd0, link_we}, 32'd0);
      chk("R9 no restore", {31'd0, status_restore}, 32'd0);
    end
  endtask

  task automatic t_zero_reg();
    idle_inputs(); cur_pc = 32'h0000_0B00; ctl_class = 4'd8;
    rega_idx = 5'd0; rega_val = 32'hDEAD_BEE0;
    step();
    chk("R10 jind r0", next_pc, 32'h0);
    ctl_class = 4'd4; br_cond = 3'd0; imm16 = 16'h0020;
    rega_idx = 5'd0; regb_idx = 5'd0;
    rega_val = 32'h5; regb_val = 32'h9;
    step();
    chk("R10 cond r0 eq taken", next_pc, rel_t(32'h0000_0B00, 16'h0020));
    regb_idx = 5'd4; regb_val = 32'h0;
    rega_val = 32'hFFFF_FFFF; br_cond = 3'd3;
    step();
    chk("R10 cond r0 lt not taken", next_pc, 32'h0000_0B04);
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_jump_abs();
    t_call_abs();
    t_branch();
    t_cond();
    t_returns();
    t_indirect();
    t_nextpc();
    t_nonctl();
    t_zero_reg();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule